// File: doc/BRIEF.md
# Two-dimensional frame memory address pointer

This block produces the linear word address for one port (write or read) of a line-oriented video frame memory. It runs on that port's own clock. Each clock edge with the gate input high is one access, and the pointer then moves on by one word. The pointer is held as a dot counter, a line counter and a registered line base, so the address is always `line × dots_per_line + dot`. The line base is kept by adding the line length, and no multiplier is used.

A two-bit mode input selects the organisation. Two of the codes select a 2-D geometry; both cover the same total capacity. The other two codes treat the memory as a single linear run. Three controls act on any edge:
- a frame reset returns the pointer to the origin;
- a line reset ends the current line early, so shorter lines are possible;
- a jump moves the pointer to a start address that was loaded beforehand.

The line-increment input decides whether a line start moves to the next line or rescans the same line. The jump target is shifted in serially, in units of 2^JUMP_LSB words. After the strobe falls, the block spends a short setup phase turning the target into line and dot form.

Top module: `fm_addr_ptr`

## Requirements
- R1: While `rst_n` is low the pointer is at address 0 and no jump target is pending. A jump issued before a new target is loaded has no effect.
- R2: Mode `2'b01` selects DOTS_A dots by LINES_A lines. Mode `2'b10` selects DOTS_B by LINES_B. Modes `2'b00` and `2'b11` select one line of DOTS_A×LINES_A words. The address is always line × dots_per_line + dot.
- R3: On each edge with `gate` high and no control active, the address rises by one word. With `line_inc` high the address wraps from the last word of the frame to 0. The address never reaches DOTS_A×LINES_A.
- R4: On an edge with `gate` low and no control active, the address is unchanged.
- R5: `frame_rst` makes the address 0 for the next access, whatever `gate` and the other controls are doing.
- R6: `line_rst` sets the dot to 0, whether `gate` is high or low. The line then follows `line_inc`, as at a natural line end.
- R7: At a line start, `line_inc` high moves to the next line, and from the last line it moves to line 0. `line_inc` low keeps the same line, so that line is scanned again.
- R8: While `set_strobe` is high, `set_data` is shifted in MSB first, one bit per clock. The last AW−JUMP_LSB bits are kept. The target is that value × 2^JUMP_LSB. The falling edge of `set_strobe` starts the setup phase.
- R9: `jump` has an effect only when setup is complete. It is ignored while `set_strobe` is high and during the setup phase. Once setup is done, the next access uses the target, taken modulo the frame capacity. The target stays available for later jumps.
- R10: When several controls fall on the same edge, priority is `frame_rst`, then `jump`, then `line_rst`, then the normal gated advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Organisation select (01, 10: 2-D shapes; 00, 11: linear) |
| gate | input | 1 | Access enable; low freezes the pointer |
| frame_rst | input | 1 | Return to the frame origin |
| line_rst | input | 1 | End the current line now |
| line_inc | input | 1 | 1: next line at line start; 0: rescan the same line |
| set_strobe | input | 1 | Frames the serial load of the jump target |
| set_data | input | 1 | Serial jump target, MSB first |
| jump | input | 1 | Move to the loaded target |
| addr | output | AW | Word address for the current access (AW = ceil(log2(DOTS_A×LINES_A))) |

## Verification
The jump and the line reset can land on the same edge. A frame reset can land on both of them and on a gated advance. The bench drives these inputs together on one edge and checks where the address lands. A jump with a line reset and an advance must land on the jump target. Adding a frame reset must give 0. A line reset with an advance must give the next line's start, not the next dot. Jumps are also issued while the strobe is high and during the setup phase. The bench checks that the address stays put until setup ends.

// File: rtl/fm_addr_ptr.sv
`timescale 1ns/1ps
module fm_addr_ptr #(
  parameter int DOTS_A   = 1152,
  parameter int LINES_A  = 288,
  parameter int DOTS_B   = 1024,
  parameter int LINES_B  = 324,
  parameter int JUMP_LSB = 5,
  localparam int CAP  = DOTS_A * LINES_A,
  localparam int AW   = $clog2(CAP),
  localparam int LMAX = (LINES_A > LINES_B) ? LINES_A : LINES_B,
  localparam int LW   = $clog2(LMAX + 1),
  localparam int JW   = AW - JUMP_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          gate,
  input  logic          frame_rst,
  input  logic          line_rst,
  input  logic          line_inc,
  input  logic          set_strobe,
  input  logic          set_data,
  input  logic          jump,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] dlast;
  logic [LW-1:0] llast;

  always_comb begin
    case (mode)
      2'b01:   begin dlast = AW'(DOTS_A - 1); llast = LW'(LINES_A - 1); end
      2'b10:   begin dlast = AW'(DOTS_B - 1); llast = LW'(LINES_B - 1); end
      default: begin dlast = AW'(CAP - 1);    llast = '0;               end
    endcase
  end

  logic [AW-1:0] dot, base;
  logic [LW-1:0] line;

  logic [JW-1:0] sreg;
  logic          strobe_q, busy, jvalid;
  logic [AW-1:0] cv_rem, cv_base;
  logic [LW-1:0] cv_line;

  logic          take_jump, eol;
  logic [LW-1:0] nl_line;
  logic [AW-1:0] nl_base;

  assign addr      = base + dot;
  assign eol       = (dot == dlast);
  assign take_jump = jump && jvalid && !set_strobe;

  always_comb begin
    nl_line = line;
    nl_base = base;
    if (line_inc) begin
      if (line == llast) begin
        nl_line = '0;
        nl_base = '0;
      end else begin
        nl_line = line + LW'(1);
        nl_base = base + dlast + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot  <= '0;
      line <= '0;
      base <= '0;
    end else if (frame_rst) begin
      dot  <= '0;
      line <= '0;
      base <= '0;
    end else if (take_jump) begin
      dot  <= cv_rem;
      line <= cv_line;
      base <= cv_base;
    end else if (line_rst || (gate && eol)) begin
      dot  <= '0;
      line <= nl_line;
      base <= nl_base;
    end else if (gate) begin
      dot  <= dot + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      sreg     <= '0;
      busy     <= 1'b0;
      jvalid   <= 1'b0;
      cv_rem   <= '0;
      cv_line  <= '0;
      cv_base  <= '0;
    end else begin
      strobe_q <= set_strobe;
      if (set_strobe) begin
        sreg   <= {sreg[JW-2:0], set_data};
        busy   <= 1'b0;
        jvalid <= 1'b0;
      end else if (strobe_q) begin
        cv_rem  <= {sreg, {JUMP_LSB{1'b0}}};
        cv_line <= '0;
        cv_base <= '0;
        busy    <= 1'b1;
        jvalid  <= 1'b0;
      end else if (busy) begin
        if (cv_rem > dlast) begin
          cv_rem <= cv_rem - dlast - AW'(1);
          if (cv_line == llast) begin
            cv_line <= '0;
            cv_base <= '0;
          end else begin
            cv_line <= cv_line + LW'(1);
            cv_base <= cv_base + dlast + AW'(1);
          end
        end else begin
          busy   <= 1'b0;
          jvalid <= 1'b1;
        end
      end
    end
  end

  p_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rst |=> addr == '0);

  p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(addr) < CAP);

  p_dot_in_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dot <= dlast);

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !frame_rst && !jump && !line_rst) |=> $stable(addr));

  p_jump_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (jump && (set_strobe || busy) && !frame_rst && !line_rst && !gate) |=> $stable(addr));

  p_line_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rst && !frame_rst && !take_jump) |=> dot == '0);

  p_setup_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(set_strobe) |=> (busy && !jvalid));

endmodule

// File: tb/fm_addr_ptr_test.sv
`timescale 1ns/1ps
module fm_addr_ptr_test;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic gate = 0, frame_rst = 0, line_rst = 0, line_inc = 1;
  logic set_strobe = 0, set_data = 0, jump = 0;
  logic [AW-1:0] addr;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  fm_addr_ptr #(.DOTS_A(12), .LINES_A(4), .DOTS_B(8), .LINES_B(6), .JUMP_LSB(2)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .gate(gate), .frame_rst(frame_rst),
    .line_rst(line_rst), .line_inc(line_inc), .set_strobe(set_strobe),
    .set_data(set_data), .jump(jump), .addr(addr));

  task automatic chk(string tag, int exp);
    total++;
    if (int'(addr) != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, addr, exp);
    end
  endtask

  task automatic adv(int n);
    gate = 1;
    repeat (n) @(negedge clk);
    gate = 0;
  endtask

  task automatic frst();
    frame_rst = 1;
    @(negedge clk);
    frame_rst = 0;
  endtask

  task automatic load(int nbits, int val, int settle);
    set_strobe = 1;
    for (int i = nbits - 1; i >= 0; i--) begin
      set_data = val[i];
      @(negedge clk);
    end
    set_strobe = 0;
    repeat (settle) @(negedge clk);
  endtask

  task automatic do_jump();
    jump = 1;
    @(negedge clk);
    jump = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", 0);
    rst_n = 1;
    @(negedge clk);
    do_jump();
    chk("R1 jump with nothing loaded", 0);
  endtask

  task automatic t_advance();
    mode = 2'b01; line_inc = 1;
    frst();
    chk("R5 origin", 0);
    adv(13);
    chk("R3 linear advance", 13);
    adv(34);
    chk("R3 last word", 47);
    adv(1);
    chk("R3 frame wrap", 0);
  endtask

  task automatic t_hold();
    mode = 2'b10; frst();
    line_inc = 1; adv(9);
    chk("R2 geometry B advance", 9);
    line_inc = 0; adv(7);
    chk("R7 hold rescans line 1 (B)", 8);
    line_inc = 1; adv(40);
    chk("R7 last line to line 0 (B)", 0);
    mode = 2'b01; frst();
    adv(13);
    line_inc = 0; adv(11);
    chk("R7 hold rescans line 1 (A)", 12);
    mode = 2'b00; frst();
    adv(48);
    chk("R2 linear single line wrap", 0);
    adv(5);
    chk("R2 linear advance", 5);
    line_inc = 1;
  endtask

  task automatic t_gate();
    repeat (5) @(negedge clk);
    chk("R4 gate low freezes", 5);
  endtask

  task automatic t_line_rst();
    mode = 2'b01; frst();
    adv(5);
    line_rst = 1; @(negedge clk); line_rst = 0;
    chk("R6 line reset next line", 12);
    adv(3);
    line_inc = 0;
    line_rst = 1; @(negedge clk); line_rst = 0;
    chk("R6 line reset hold", 12);
    line_inc = 1; gate = 1; line_rst = 1;
    @(negedge clk);
    line_rst = 0; gate = 0;
    chk("R10 line reset beats advance", 24);
  endtask

  task automatic t_jump();
    mode = 2'b01; frst();
    load(4, 5, 8);
    do_jump();
    chk("R9 jump to target", 20);
    adv(1);
    chk("R9 access after jump", 21);
    line_inc = 0; adv(3);
    chk("R8 target mapped to line 1", 12);
    line_inc = 1;
    do_jump();
    chk("R9 target reusable", 20);
    frst();
    jump = 1; line_rst = 1; gate = 1;
    @(negedge clk);
    jump = 0; line_rst = 0; gate = 0;
    chk("R10 jump beats line reset", 20);
    frame_rst = 1; jump = 1; line_rst = 1; gate = 1;
    @(negedge clk);
    frame_rst = 0; jump = 0; line_rst = 0; gate = 0;
    chk("R10 frame reset beats all", 0);
  endtask

  task automatic t_linear_jump();
    mode = 2'b00; frst();
    load(6, 6'b110101, 4);
    do_jump();
    chk("R8 last bits kept", 20);
    adv(28);
    chk("R3 linear wrap after jump", 0);
  endtask

  task automatic t_blocked_jump();
    mode = 2'b01; frst();
    set_strobe = 1;
    for (int i = 3; i >= 0; i--) begin
      set_data = 1'b1;
      if (i == 2) jump = 1;
      @(negedge clk);
    end
    chk("R9 jump ignored while shifting", 0);
    set_strobe = 0;
    @(negedge clk);
    @(negedge clk);
    jump = 0;
    chk("R9 jump ignored during setup", 0);
    repeat (10) @(negedge clk);
    do_jump();
    chk("R9 target modulo capacity", 12);
  endtask

  initial begin
    t_reset();
    t_advance();
    t_hold();
    t_gate();
    t_line_rst();
    t_jump();
    t_linear_jump();
    t_blocked_jump();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule